// File: doc/BRIEF.md
# Four-Lane Float Result Flag Generator

This block looks at a vector result made of several single-precision floating-point lanes and works out a condition flag for each lane in four classes: not-a-number (reported as overflow), denormal (reported as underflow), negative nonzero, and zero. It packs these per-lane flags into a condition word with one nibble per class. It also folds them into a compact status word that has current and sticky summary bits. A lane-enable mask decides which lanes take part, so a partial-width vector operation reports only the lanes it wrote.

An optional flush replaces each denormal lane with a zero that keeps the lane's sign. The block returns this cleaned vector combinationally, so the datapath can write it back. The sign and zero classes are judged on the flushed value, while the underflow class is always judged on the raw input. The condition word and the current summary load on a write strobe. The sticky summary collects every strobed summary until an explicit clear or a reset.

Top module: `lane_flag_unit`

## Requirements
- R1: Lane k occupies vector bits [32k+31:32k] and maps to bit k of every nibble, so the top lane (bits 127:96) is nibble bit 3. The condition word is {overflow[15:12], underflow[11:8], sign[7:4], zero[3:0]}.
- R2: A lane sets its overflow bit exactly when its exponent is all ones and its mantissa is nonzero. An infinity (mantissa zero) leaves overflow clear.
- R3: A lane sets its underflow bit exactly when its exponent is zero and its mantissa is nonzero. This holds whether or not flushing is on.
- R4: A lane sets its sign bit when its sign bit is 1 and its value after any flush is not zero. Negative zero leaves sign clear, and negative infinity sets it.
- R5: A lane sets its zero bit when its value after any flush is +0 or -0. With flushing off, a denormal is not zero.
- R6: With flush_en high, clean_vec carries each denormal lane as a zero with its original sign and passes every other lane unchanged. With flush_en low, clean_vec equals res_vec.
- R7: A lane whose bit in lane_en is 0 adds 0 to every condition bit and every summary bit.
- R8: status_word[3:0] holds the OR across lanes of zero (bit 0), sign (bit 1), underflow (bit 2) and overflow (bit 3). Bits 5:4 always read 0.
- R9: status_word[9:6] (same class order as R8) ORs in the new summary on every strobe. clr_sticky clears it, and on a cycle with both a strobe and a clear, the clear wins.
- R10: mac_word and status_word[3:0] load on a clock edge with wr_stb high and hold otherwise.
- R11: A synchronous reset clears mac_word and status_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vec | input | 128 | Result vector, four single-precision lanes |
| lane_en | input | 4 | Per-lane participation mask |
| wr_stb | input | 1 | Load condition word and summaries |
| flush_en | input | 1 | Flush denormals to signed zero |
| clr_sticky | input | 1 | Clear the sticky summary bits |
| mac_word | output | 16 | Registered per-lane condition word |
| status_word | output | 10 | Current summary [3:0], sticky summary [9:6] |
| clean_vec | output | 128 | res_vec with denormals flushed when enabled |

## Verification
The bench builds the block with its defaults: four lanes of 8-bit exponent and 23-bit mantissa. At that size every one of the sixteen enable masks can be reached, and each lane can be driven with a value from every encoding class: signed zeros, denormals, NaNs, infinities and normals. The random stimulus mixes these classes in each lane, so the flushed-sign, negative-zero and infinity corners occur often and in all lane positions. Directed steps pin the nibble layout, the strobe hold and the priority of clear over strobe.

// File: rtl/lane_flag_pkg.sv
package lane_flag_pkg;

    localparam int CLS_N      = 4;
    localparam int ST_ZRO     = 0;
    localparam int ST_SGN     = 1;
    localparam int ST_UNF     = 2;
    localparam int ST_OVF     = 3;
    localparam int STICKY_LSB = 6;
    localparam int STAT_W     = STICKY_LSB + CLS_N;
    localparam int GAP_W      = STICKY_LSB - CLS_N;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic sgn;
        logic zro;
    } lane_cls_t;

    // Classify a lane from its decoded fields; zero/sign see the flushed value.
    function automatic lane_cls_t classify(input logic sgn, input logic ex_max,
                                           input logic ex_min, input logic man_nz,
                                           input logic flush);
        lane_cls_t c;
        logic      is_zero;
        is_zero = ex_min & (~man_nz | flush);
        c.ovf   = ex_max & man_nz;
        c.unf   = ex_min & man_nz;
        c.zro   = is_zero;
        c.sgn   = sgn & ~is_zero;
        return c;
    endfunction

endpackage

// File: rtl/lane_inspect.sv
module lane_inspect
    import lane_flag_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FP_W = 1 + EXP_W + MAN_W
) (
    input  logic [FP_W-1:0] lane_i,
    input  logic            flush_i,
    output lane_cls_t       cls_o,
    output logic [FP_W-1:0] lane_o
);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic             ex_max;
    logic             ex_min;
    logic             man_nz;

    assign {sgn, ex, man} = lane_i;

    always_comb begin
        ex_max = &ex;
        ex_min = ~|ex;
        man_nz = |man;
        cls_o  = classify(sgn, ex_max, ex_min, man_nz, flush_i);
        if (flush_i && ex_min && man_nz)
            lane_o = {sgn, {(FP_W-1){1'b0}}};
        else
            lane_o = lane_i;
    end

endmodule

// File: rtl/flag_collect.sv
module flag_collect
    import lane_flag_pkg::*;
#(
    parameter int LANES = 4,
    localparam int MAC_W = CLS_N * LANES
) (
    input  lane_cls_t [LANES-1:0] cls_i,
    input  logic [LANES-1:0]      en_i,
    output logic [MAC_W-1:0]      mac_o,
    output logic [CLS_N-1:0]      sum_o
);

    logic [LANES-1:0] ovf_v;
    logic [LANES-1:0] unf_v;
    logic [LANES-1:0] sgn_v;
    logic [LANES-1:0] zro_v;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign ovf_v[k] = cls_i[k].ovf & en_i[k];
        assign unf_v[k] = cls_i[k].unf & en_i[k];
        assign sgn_v[k] = cls_i[k].sgn & en_i[k];
        assign zro_v[k] = cls_i[k].zro & en_i[k];
    end

    assign mac_o = {ovf_v, unf_v, sgn_v, zro_v};

    always_comb begin
        sum_o         = '0;
        sum_o[ST_ZRO] = |zro_v;
        sum_o[ST_SGN] = |sgn_v;
        sum_o[ST_UNF] = |unf_v;
        sum_o[ST_OVF] = |ovf_v;
    end

endmodule

// File: rtl/flag_store.sv
module flag_store
    import lane_flag_pkg::*;
#(
    parameter int LANES = 4,
    localparam int MAC_W = CLS_N * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              clr_i,
    input  logic [MAC_W-1:0]  mac_d,
    input  logic [CLS_N-1:0]  sum_d,
    output logic [MAC_W-1:0]  mac_q,
    output logic [STAT_W-1:0] status_q
);

    logic [CLS_N-1:0] sum_q;
    logic [CLS_N-1:0] sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mac_q    <= '0;
            sum_q    <= '0;
            sticky_q <= '0;
        end else begin
            if (wr_i) begin
                mac_q <= mac_d;
                sum_q <= sum_d;
            end
            if (clr_i)
                sticky_q <= '0;
            else if (wr_i)
                sticky_q <= sticky_q | sum_d;
        end
    end

    assign status_q = {sticky_q, {GAP_W{1'b0}}, sum_q};

endmodule

// File: rtl/lane_flag_unit.sv
module lane_flag_unit
    import lane_flag_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FP_W  = 1 + EXP_W + MAN_W,
    localparam int VEC_W = FP_W * LANES,
    localparam int MAC_W = CLS_N * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VEC_W-1:0]  res_vec,
    input  logic [LANES-1:0]  lane_en,
    input  logic              wr_stb,
    input  logic              flush_en,
    input  logic              clr_sticky,
    output logic [MAC_W-1:0]  mac_word,
    output logic [STAT_W-1:0] status_word,
    output logic [VEC_W-1:0]  clean_vec
);

    lane_cls_t [LANES-1:0] lane_cls;
    logic [MAC_W-1:0]      mac_next;
    logic [CLS_N-1:0]      sum_next;

    for (genvar k = 0; k < LANES; k++) begin : g_inspect
        lane_inspect #(
            .EXP_W(EXP_W),
            .MAN_W(MAN_W)
        ) insp_i (
            .lane_i (res_vec[k*FP_W +: FP_W]),
            .flush_i(flush_en),
            .cls_o  (lane_cls[k]),
            .lane_o (clean_vec[k*FP_W +: FP_W])
        );
    end

    flag_collect #(.LANES(LANES)) coll_i (
        .cls_i(lane_cls),
        .en_i (lane_en),
        .mac_o(mac_next),
        .sum_o(sum_next)
    );

    flag_store #(.LANES(LANES)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_stb),
        .clr_i   (clr_sticky),
        .mac_d   (mac_next),
        .sum_d   (sum_next),
        .mac_q   (mac_word),
        .status_q(status_word)
    );

endmodule

// File: rtl/lane_flag_unit_chk.sv
module lane_flag_unit_chk
    import lane_flag_pkg::*;
#(
    parameter int LANES = 4,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FP_W  = 1 + EXP_W + MAN_W,
    localparam int VEC_W = FP_W * LANES,
    localparam int MAC_W = CLS_N * LANES
) (
    input logic              clk,
    input logic              rst,
    input logic [VEC_W-1:0]  res_vec,
    input logic [LANES-1:0]  lane_en,
    input logic              wr_stb,
    input logic              flush_en,
    input logic              clr_sticky,
    input logic [MAC_W-1:0]  mac_word,
    input logic [STAT_W-1:0] status_word,
    input logic [VEC_W-1:0]  clean_vec
);

    // R10: no strobe, no change in condition word or current summary
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(mac_word) && $stable(status_word[CLS_N-1:0]));

    // R7: disabled lanes leave every nibble bit clear
    p_masked_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (mac_word & ~{CLS_N{$past(lane_en)}}) == '0);

    // R4 and R5: a lane is never both signed and zero
    p_sign_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (mac_word[2*LANES-1:LANES] & mac_word[LANES-1:0]) == '0);

    // R2 and R3: a NaN lane is neither denormal nor zero
    p_no_overflow_mix_r2: assert property (@(posedge clk) disable iff (rst)
        (mac_word[4*LANES-1:3*LANES] &
         (mac_word[3*LANES-1:2*LANES] | mac_word[LANES-1:0])) == '0);

    // R8: summary agrees with the condition word; gap bits stay low
    p_summary_r8: assert property (@(posedge clk) disable iff (rst)
        status_word[ST_ZRO] == |mac_word[LANES-1:0] &&
        status_word[ST_OVF] == |mac_word[4*LANES-1:3*LANES] &&
        status_word[STICKY_LSB-1:CLS_N] == '0);

    // R9: after a strobe without clear, sticky covers the current summary
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wr_stb && !clr_sticky |=>
        (status_word[CLS_N-1:0] & ~status_word[STAT_W-1:STICKY_LSB]) == '0);

    // R9: clear wins
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_sticky |=> status_word[STAT_W-1:STICKY_LSB] == '0);

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R6: sign bit of every lane passes through unchanged
        p_sign_kept_r6: assert property (@(posedge clk) disable iff (rst)
            clean_vec[k*FP_W+FP_W-1] == res_vec[k*FP_W+FP_W-1]);
        // R6: with flush on, a zero-exponent lane comes out with zero magnitude
        p_flush_r6: assert property (@(posedge clk) disable iff (rst)
            flush_en && res_vec[k*FP_W+MAN_W +: EXP_W] == '0 |->
            clean_vec[k*FP_W +: FP_W-1] == '0);
    end

endmodule

bind lane_flag_unit lane_flag_unit_chk #(
    .LANES(LANES),
    .EXP_W(EXP_W),
    .MAN_W(MAN_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .res_vec    (res_vec),
    .lane_en    (lane_en),
    .wr_stb     (wr_stb),
    .flush_en   (flush_en),
    .clr_sticky (clr_sticky),
    .mac_word   (mac_word),
    .status_word(status_word),
    .clean_vec  (clean_vec)
);

// File: tb/lane_flag_unit_tb_top.sv
module lane_flag_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] res_vec = '0;
    logic [3:0]   lane_en = '0;
    logic         wr_stb = 1'b0;
    logic         flush_en = 1'b0;
    logic         clr_sticky = 1'b0;
    logic [15:0]  mac_word;
    logic [9:0]   status_word;
    logic [127:0] clean_vec;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_mac = '0;
    logic [3:0]  m_sum = '0;
    logic [3:0]  m_st  = '0;

    always #4 clk = ~clk;

    lane_flag_unit dut_i (
        .clk(clk), .rst(rst), .res_vec(res_vec), .lane_en(lane_en),
        .wr_stb(wr_stb), .flush_en(flush_en), .clr_sticky(clr_sticky),
        .mac_word(mac_word), .status_word(status_word), .clean_vec(clean_vec)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {ovf, unf, sgn, zro} of one lane, from the encoding rules
    function automatic logic [3:0] ref_lane(input logic [31:0] v, input logic fl);
        int  e = int'(v[30:23]);
        bit  mnz = (v[22:0] != 0);
        bit  z = (e == 0) && (!mnz || fl);
        return {e == 255 && mnz, e == 0 && mnz, v[31] && !z, z};
    endfunction

    function automatic logic [31:0] pick_lane(input int kind, input logic [31:0] r);
        logic [7:0] e = r[30:23];
        if (e == 8'h00 || e == 8'hFF) e = 8'h41;
        case (kind)
            0: return {r[31], 31'h0};
            1: return {r[31], 8'h00, r[22:0] | 23'h1};
            2: return {r[31], 8'hFF, r[22:0] | 23'h1};
            3: return {r[31], 8'hFF, 23'h0};
            default: return {r[31], e, r[22:0]};
        endcase
    endfunction

    task automatic step(input logic [127:0] v, input logic [3:0] en,
                        input logic stb, input logic fl, input logic clr);
        logic [15:0]  nmac = '0;
        logic [3:0]   nsum;
        logic [127:0] ncl;
        res_vec = v; lane_en = en; wr_stb = stb; flush_en = fl; clr_sticky = clr;
        ncl = v;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] c = ref_lane(v[k*32 +: 32], fl);
            if (en[k]) begin
                nmac[12+k] = c[3]; nmac[8+k] = c[2]; nmac[4+k] = c[1]; nmac[k] = c[0];
            end
            if (fl && c[2]) ncl[k*32 +: 32] = {v[k*32+31], 31'h0};
        end
        #1;
        chk("R6 clean vector", clean_vec, ncl);
        nsum = {|nmac[15:12], |nmac[11:8], |nmac[7:4], |nmac[3:0]};
        if (stb) begin m_mac = nmac; m_sum = nsum; end
        if (clr) m_st = '0; else if (stb) m_st = m_st | nsum;
        @(posedge clk); @(negedge clk);
        chk("R2 overflow nibble", 128'(mac_word[15:12]), 128'(m_mac[15:12]));
        chk("R3 underflow nibble", 128'(mac_word[11:8]), 128'(m_mac[11:8]));
        chk("R4 sign nibble", 128'(mac_word[7:4]), 128'(m_mac[7:4]));
        chk("R5 zero nibble", 128'(mac_word[3:0]), 128'(m_mac[3:0]));
        chk("R8 summary", 128'(status_word[5:0]), 128'({2'b00, m_sum}));
        chk("R9 sticky", 128'(status_word[9:6]), 128'(m_st));
    endtask

    localparam logic [31:0] NAN  = 32'h7FC0_0001;
    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] NZER = 32'h8000_0000;
    localparam logic [31:0] NDEN = 32'h8000_0123;
    localparam logic [31:0] ONE  = 32'h3F80_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset mac", 128'(mac_word), 128'h0);
        chk("R11 reset status", 128'(status_word), 128'h0);
        rst = 1'b0;

        // R1: NaN only in the top lane lands in bit 15
        step({NAN, ONE, ONE, ONE}, 4'hF, 1, 0, 0);
        chk("R1 lane x to bit 15", 128'(mac_word), 128'h8000);
        // R2/R4: +inf in lane y has no flag; -inf sets its sign bit 6
        step({ONE, PINF, ONE, ONE}, 4'hF, 1, 0, 0);
        chk("R2 +inf no flag", 128'(mac_word), 128'h0000);
        step({ONE, NINF, ONE, ONE}, 4'hF, 1, 0, 0);
        chk("R4 -inf sign", 128'(mac_word), 128'h0040);
        // R5/R4: negative zero in lane z is zero, not signed
        step({ONE, ONE, NZER, ONE}, 4'hF, 1, 0, 0);
        chk("R5 negative zero", 128'(mac_word), 128'h0002);
        // R3/R5: negative denormal in lane w, flush off then on
        step({ONE, ONE, ONE, NDEN}, 4'hF, 1, 0, 0);
        chk("R3 denormal unflushed", 128'(mac_word), 128'h0110);
        step({ONE, ONE, ONE, NDEN}, 4'hF, 1, 1, 0);
        chk("R3 denormal flushed", 128'(mac_word), 128'h0101);
        chk("R6 flushed lane", 128'(clean_vec[31:0]), 128'(NZER));
        // R7: all lanes NaN, only lanes 2 and 0 enabled
        step({NAN, NAN, NAN, NAN}, 4'b0101, 1, 0, 0);
        chk("R7 masked lanes", 128'(mac_word), 128'h5000);
        step({NAN, NAN, NAN, NAN}, 4'b0000, 1, 0, 0);
        chk("R7 all masked", 128'(status_word[3:0]), 128'h0);
        // R10: new data without strobe does not load
        step({ONE, ONE, NZER, NZER}, 4'hF, 1, 0, 0);
        step({NAN, NDEN, NINF, NAN}, 4'hF, 0, 0, 0);
        chk("R10 hold", 128'(mac_word), 128'h0003);
        // R9: clear wins over a strobe in the same cycle
        step({NAN, NDEN, NINF, NAN}, 4'hF, 1, 0, 1);
        chk("R9 clear priority", 128'(status_word[9:6]), 128'h0);
        step({NAN, NDEN, NINF, NAN}, 4'hF, 0, 0, 0);

        for (int i = 0; i < 400; i++) begin
            logic [127:0] v;
            for (int k = 0; k < 4; k++)
                v[k*32 +: 32] = pick_lane(int'($urandom_range(0, 5)), $urandom);
            step(v, 4'($urandom), ($urandom_range(0, 3) != 0),
                 1'($urandom), ($urandom_range(0, 9) == 0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule